// File: doc/BRIEF.md
# Phase-to-Sine Converter with Table Correction

This block turns a phase word into a signed sine sample. A single table indexed by every phase bit would be too large, and dropping the low phase bits gives large spurious tones. The block takes a middle path. The upper phase bits (the coarse angle) address a sine table. The lower phase bits (the fine angle) are used for a small correction. The identity sin(A+B) = sin A cos B + cos A sin B is applied with cos B taken as exactly 1. The cos A · sin B term is always small, so it is read from a second table. That table is addressed only by the leading bits of the coarse angle and of the fine angle, and no multiplier is used.

The block sits after a phase accumulator and feeds a DAC or later filtering. It takes a new phase every clock. The sample for that phase appears two clocks later. The sum of the two table values is clamped to a symmetric range, so it never wraps around.

Top module: `phase_to_sine`

## Requirements
- R1: While `rst` is high, and after the first rising edge that follows its release, `sampleOut` is 0. The first real sample appears after the second rising edge after release.
- R2: The coarse value is round(32767·sin(2π·A/1024)), where A = phaseIn[15:6]. Rounding is to the nearest integer, with halves rounded away from zero.
- R3: The correction value is round(32767·cos(2π·(a+0.5)/32)·sin(2π·(4·b+1.5)/65536)), where a = phaseIn[15:11] and b = phaseIn[5:2]. phaseIn[1:0] has no effect.
- R4: The output equals the coarse value plus the correction value, before any clamping.
- R5: For every phase p, |sampleOut − 32767·sin(2π·p/65536)| ≤ 32.
- R6: A sum above 32767 becomes 32767 and a sum below −32767 becomes −32767. The code −32768 (16'h8000) is never produced.
- R7: A new phase is accepted on every rising edge. The phase sampled at edge k appears on `sampleOut` after edge k+1, which gives a latency of 2 clocks.
- R8: When the phase sampled two edges earlier had phaseIn[15] = 0, the output is ≥ 0. When that bit was 1, the output is ≤ 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| phaseIn | input | 16 | Unsigned phase, full scale is one turn |
| sampleOut | output | 16 | Signed sine sample, two's complement |

## Verification
The hardest case to reach is the clamp. It happens only in a few narrow phase bands just short of ±90 degrees, where the coarse table is already near full scale and the correction, computed at a bin-centred coarse angle, still pushes the sum outward. The zero-crossing bins are almost as delicate: there the correction almost cancels the coarse value, so the sign rule is at its tightest. The bench sweeps all 65536 phases, one per clock, so every such band is reached. It compares each sample exactly against the table formulas and against a real-valued sine. A scrambled-order run and a mid-stream reset then cover back-to-back phase jumps and the refill of the pipeline.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureEn;  // stage 1 table reads
    logic emitEn;     // stage 2 sum is valid and may be published
  } ctlStrobes_t;

  localparam real TWO_PI = 6.283185307179586;

  // Nearest integer, halves away from zero
  function automatic int roundNear(real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(-x + 0.5);
  endfunction

endpackage

// File: rtl/sfc_coarse_rom.sv
module sfc_coarse_rom #(
  parameter int A_W   = 10,
  parameter int OUT_W = 16,
  parameter int AMP   = 32767
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [A_W-1:0]          addr,
  output logic signed [OUT_W-1:0] data
);
  localparam int DEPTH = 1 << A_W;

  logic signed [OUT_W-1:0] romMem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      romMem[i] = OUT_W'(sfc_pkg::roundNear(
        real'(AMP) * $sin(sfc_pkg::TWO_PI * real'(i) / real'(DEPTH))));
    end
  end

  always_ff @(posedge clk) begin
    if (en) data <= romMem[addr];
  end
endmodule

// File: rtl/sfc_fix_rom.sv
module sfc_fix_rom #(
  parameter int PHASE_W = 16,
  parameter int A_W     = 5,   // coarse-angle bits used
  parameter int B_W     = 4,   // fine-angle bits used
  parameter int FINE_W  = 6,   // full fine-angle width
  parameter int FIX_W   = 9,
  parameter int AMP     = 32767
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [A_W-1:0]          aIdx,
  input  logic [B_W-1:0]          bIdx,
  output logic signed [FIX_W-1:0] data
);
  localparam int A_DEPTH = 1 << A_W;
  localparam int B_DEPTH = 1 << B_W;
  localparam int DEPTH   = A_DEPTH * B_DEPTH;
  localparam int B_STEP  = 1 << (FINE_W - B_W);   // fine LSBs per bin
  localparam real B_MID  = real'(B_STEP - 1) / 2.0;
  localparam real TURN   = real'(64'd1 << PHASE_W);

  logic signed [FIX_W-1:0] romMem [DEPTH];

  initial begin
    for (int a = 0; a < A_DEPTH; a++) begin
      for (int b = 0; b < B_DEPTH; b++) begin
        romMem[a*B_DEPTH + b] = FIX_W'(sfc_pkg::roundNear(
          real'(AMP)
          * $cos(sfc_pkg::TWO_PI * (real'(a) + 0.5) / real'(A_DEPTH))
          * $sin(sfc_pkg::TWO_PI * (real'(b * B_STEP) + B_MID) / TURN)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en) data <= romMem[{aIdx, bIdx}];
  end
endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl (
  input  logic                clk,
  input  logic                rst,
  output sfc_pkg::ctlStrobes_t strobes
);
  logic primed;  // stage 1 holds table data read from a real phase

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  always_comb begin
    strobes.captureEn = ~rst;
    strobes.emitEn    = primed;
  end
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath #(
  parameter int PHASE_W  = 16,
  parameter int COARSE_W = 10,
  parameter int FIX_A_W  = 5,
  parameter int FIX_B_W  = 4,
  parameter int OUT_W    = 16,
  parameter int FIX_W    = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  sfc_pkg::ctlStrobes_t    strobes,
  input  logic [PHASE_W-1:0]      phaseIn,
  output logic signed [OUT_W-1:0] sampleOut
);
  localparam int FINE_W = PHASE_W - COARSE_W;
  localparam int AMP    = (1 << (OUT_W - 1)) - 1;
  localparam int SUM_W  = OUT_W + 1;
  localparam int LSB_W  = FINE_W - FIX_B_W;
  localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'(AMP);
  localparam logic signed [SUM_W-1:0] NEG_LIM = -SUM_W'(AMP);

  logic [COARSE_W-1:0]     coarseIdx;
  logic [FIX_A_W-1:0]      fixA;
  logic [FIX_B_W-1:0]      fixB;
  logic                    unusedLsbs;
  logic signed [OUT_W-1:0] coarseQ;
  logic signed [FIX_W-1:0] fixQ;
  logic signed [SUM_W-1:0] sumWide;
  logic signed [OUT_W-1:0] clamped;

  assign coarseIdx  = phaseIn[PHASE_W-1 -: COARSE_W];
  assign fixA       = phaseIn[PHASE_W-1 -: FIX_A_W];
  assign fixB       = phaseIn[FINE_W-1 -: FIX_B_W];
  assign unusedLsbs = ^phaseIn[LSB_W-1:0];

  sfc_coarse_rom #(.A_W(COARSE_W), .OUT_W(OUT_W), .AMP(AMP)) u_coarse (
    .clk(clk), .en(strobes.captureEn), .addr(coarseIdx), .data(coarseQ)
  );

  sfc_fix_rom #(
    .PHASE_W(PHASE_W), .A_W(FIX_A_W), .B_W(FIX_B_W),
    .FINE_W(FINE_W), .FIX_W(FIX_W), .AMP(AMP)
  ) u_fix (
    .clk(clk), .en(strobes.captureEn), .aIdx(fixA), .bIdx(fixB), .data(fixQ)
  );

  always_comb begin
    sumWide = SUM_W'(coarseQ) + SUM_W'(fixQ);
    if (sumWide > POS_LIM)      clamped = OUT_W'(POS_LIM);
    else if (sumWide < NEG_LIM) clamped = OUT_W'(NEG_LIM);
    else                        clamped = sumWide[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                 sampleOut <= '0;
    else if (strobes.emitEn) sampleOut <= clamped;
    else                     sampleOut <= '0;
  end
endmodule

// File: rtl/phase_to_sine.sv
module phase_to_sine #(
  parameter int PHASE_W  = 16,
  parameter int COARSE_W = 10,
  parameter int FIX_A_W  = 5,
  parameter int FIX_B_W  = 4,
  parameter int OUT_W    = 16,
  parameter int FIX_W    = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PHASE_W-1:0]      phaseIn,
  output logic signed [OUT_W-1:0] sampleOut
);
  sfc_pkg::ctlStrobes_t strobes;

  sfc_ctrl u_ctrl (.clk(clk), .rst(rst), .strobes(strobes));

  sfc_datapath #(
    .PHASE_W(PHASE_W), .COARSE_W(COARSE_W), .FIX_A_W(FIX_A_W),
    .FIX_B_W(FIX_B_W), .OUT_W(OUT_W), .FIX_W(FIX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .phaseIn(phaseIn), .sampleOut(sampleOut)
  );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int PHASE_W = 16,
  parameter int OUT_W   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [PHASE_W-1:0]      phaseIn,
  input logic signed [OUT_W-1:0] sampleOut
);
  logic [2:0] age;  // edges since reset release, saturating

  always_ff @(posedge clk) begin
    if (rst)           age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R1: one edge after reset the output is still zero
  p_zero_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    (age == 3'd0) |-> (sampleOut == '0));

  // R6: the most negative code never appears
  p_no_min_code_r6: assert property (@(posedge clk) disable iff (rst)
    sampleOut != {1'b1, {(OUT_W-1){1'b0}}});

  // R8: sign follows the half-turn bit of the phase two edges back
  p_sign_r8: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3 && !$past(phaseIn[PHASE_W-1], 2)) |-> (sampleOut >= 0));

  p_sign_neg_r8: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3 && $past(phaseIn[PHASE_W-1], 2)) |-> (sampleOut <= 0));

  // R7: a held phase gives a held output two edges later
  p_steady_r7: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && $stable(phaseIn)) |=> ##1 $stable(sampleOut));
endmodule

bind phase_to_sine sfc_checker #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_sfc_checker (.*);

// File: tb/test_phase_to_sine.sv
module test_phase_to_sine;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [15:0]        phaseIn = '0;
  logic signed [15:0] sampleOut;

  int checks = 0;
  int failures = 0;
  int satHits = 0;
  bit done = 0;

  localparam real TWOPI = 6.283185307179586;

  always #10 clk = ~clk;  // 50 MHz

  phase_to_sine i_phase_to_sine (
    .clk(clk), .rst(rst), .phaseIn(phaseIn), .sampleOut(sampleOut)
  );

  function automatic int rnd(real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  // Expected sample from the requirement formulas; raw sum before clamp
  function automatic int expRaw(logic [15:0] p);
    int cA, a, b;
    cA = int'(p[15:6]);
    a  = int'(p[15:11]);
    b  = int'(p[5:2]);
    return rnd(32767.0 * $sin(TWOPI * real'(cA) / 1024.0))
         + rnd(32767.0 * $cos(TWOPI * (real'(a) + 0.5) / 32.0)
                       * $sin(TWOPI * (real'(4*b) + 1.5) / 65536.0));
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic checkSample(logic [15:0] p);
    int raw, want, act;
    real trueV, err;
    raw  = expRaw(p);
    want = (raw > 32767) ? 32767 : ((raw < -32767) ? -32767 : raw);
    if (raw != want) satHits++;
    act  = int'(sampleOut);
    // R2 R3 R4 R6 R7: exact value two clocks after the phase
    check(act == want, "R2/R3/R4/R6/R7 exact sample", act, want);
    trueV = 32767.0 * $sin(TWOPI * real'(p) / 65536.0);
    err = real'(act) - trueV;
    if (err < 0.0) err = -err;
    check(err <= 32.0, "R5 error bound", act, rnd(trueV));
    // R8: sign rule
    if (p[15]) check(act <= 0, "R8 sign second half", act, 0);
    else       check(act >= 0, "R8 sign first half", act, 0);
  endtask

  // mode 0: ascending sweep, mode 1: scrambled jumps
  task automatic runSeq(int count, int mode);
    logic [15:0] h0 = '0, h1 = '0;
    for (int n = 0; n < count + 2; n++) begin
      @(negedge clk);
      if (n >= 2) checkSample(h1);
      h1 = h0;
      if (n < count) h0 = (mode == 0) ? 16'(n) : 16'(n * 40503 + 777);
      else           h0 = 16'h0;
      phaseIn = h0;
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    phaseIn = 16'h4000;
    repeat (3) @(negedge clk);
    check(sampleOut == 0, "R1 zero in reset", int'(sampleOut), 0);
    rst = 1'b0;          // released at a falling edge, phase 0x4000 driven
    @(negedge clk);
    check(sampleOut == 0, "R1 zero one edge after release", int'(sampleOut), 0);
    @(negedge clk);
    check(sampleOut == 16'sd32767, "R1 R7 first sample at quarter turn",
          int'(sampleOut), 32767);

    runSeq(65536, 0);
    check(satHits > 0, "R6 clamp reached in sweep", satHits, 1);
    runSeq(4096, 1);

    // R1: reset mid-stream, then refill
    phaseIn = 16'hC000;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(sampleOut == 0, "R1 zero during mid-run reset", int'(sampleOut), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sampleOut == 0, "R1 zero after mid-run release", int'(sampleOut), 0);
    @(negedge clk);
    check(sampleOut == -16'sd32767, "R1 R7 refill at three-quarter turn",
          int'(sampleOut), -32767);

    // R3: the two lowest phase bits change nothing
    phaseIn = 16'h1234;
    @(negedge clk);
    phaseIn = 16'h1237;
    @(negedge clk);
    begin
      int first;
      @(negedge clk);
      first = int'(sampleOut);
      check(first == expRaw(16'h1234), "R3 base sample", first, expRaw(16'h1234));
      @(negedge clk);
      check(int'(sampleOut) == first, "R3 low bits ignored", int'(sampleOut), first);
    end

    done = 1;
    finishRun();
  end
endmodule